// File: doc/BRIEF.md
# USB Transmit Endpoint Control

This block is the control side of a single USB device transmit endpoint. A processor writes a five-bit control word and an 11-bit maximum packet size. The block counts bytes as they are pushed into the endpoint FIFO. From these it keeps a packet-ready flag, the DATA0/DATA1 toggle and a DMA request line. The serial engine reports host handshakes through two one-cycle strobes: an ACK arrived, or an isochronous packet went out. The block then retires the packet and tells the FIFO to discard its contents through a one-cycle flush pulse.

Packet-ready can be raised by software or, in automatic mode, by the byte write that fills a maximum-size packet. A forced toggle flips the data toggle and discards the queued packet without waiting for an ACK. Where the FIFO is shared between directions (parameter `SHARED_FIFO`), a direction bit chooses transmit or receive. When `SHARED_FIFO` is 0, the endpoint is always a transmitter.

Top module: `usb_txep_ctrl`

## Requirements
- R1: After reset, `ctrl_rd`, `maxp_rd`, `byte_count`, `tx_ready`, `data_toggle`, `dma_req` and `fifo_flush` are all 0.
- R2: Control word bits are: bit 0 auto-ready, bit 1 isochronous, bit 2 transmit direction, bit 3 DMA enable and bit 4 force-toggle. A write shows on `ctrl_rd` in the next cycle. Bit 4 always reads back as 0.
- R3: With auto-ready 0, `tx_ready` rises only in the cycle after `sw_ready_set`. The byte count does not affect this.
- R4: With auto-ready 1 and a nonzero maximum size, the byte write that brings `byte_count` to the maximum size sets `tx_ready` in the next cycle. A shorter packet leaves `tx_ready` at 0 until `sw_ready_set`.
- R5: A maximum packet size of 0 never raises `tx_ready` automatically.
- R6: In bulk/interrupt mode (isochronous bit 0), `ack_rcvd` while `tx_ready` is 1 does four things: it flips `data_toggle`, clears `tx_ready`, clears `byte_count` and pulses `fifo_flush` for one cycle. `pkt_sent` has no effect in this mode.
- R7: In isochronous mode, `pkt_sent` while `tx_ready` is 1 clears `tx_ready` and `byte_count` and pulses `fifo_flush`. `data_toggle` stays unchanged. `ack_rcvd` has no effect in this mode.
- R8: A control write with bit 4 set does four things: it flips `data_toggle`, clears `tx_ready` and `byte_count`, and pulses `fifo_flush`. No ACK is needed. A force and an ACK in the same cycle flip the toggle once.
- R9: `dma_req` is 1 exactly when DMA enable is 1, the transmit direction is selected and `tx_ready` is 0.
- R10: With the receive direction selected (bit 2 = 0), byte writes and `sw_ready_set` are ignored.
- R11: Byte writes while `tx_ready` is 1 leave `byte_count` unchanged.
- R12: `byte_count` saturates at 2^`MAXP_W`-1 (2047 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 5 | Control word value |
| maxp_wr_en | input | 1 | Maximum packet size write strobe |
| maxp_wr_data | input | MAXP_W | Maximum packet size value |
| fifo_wr | input | 1 | One byte pushed into the endpoint FIFO |
| sw_ready_set | input | 1 | Software sets packet-ready |
| ack_rcvd | input | 1 | Host ACK strobe |
| pkt_sent | input | 1 | Packet transmitted strobe |
| ctrl_rd | output | 5 | Control word readback |
| maxp_rd | output | MAXP_W | Maximum packet size readback |
| byte_count | output | MAXP_W | Bytes held for the pending packet |
| tx_ready | output | 1 | Packet-ready flag |
| data_toggle | output | 1 | Current DATA0/DATA1 toggle |
| dma_req | output | 1 | DMA request for more transmit data |
| fifo_flush | output | 1 | One-cycle FIFO discard pulse |

## Verification
The bench builds the block with the defaults, `MAXP_W` = 11 and `SHARED_FIFO` = 1. The shared-FIFO variant makes the receive-direction gating visible at the ports. The 11-bit count can be pushed past its limit in about two thousand byte writes, so saturation is reached directly. Small programmed maximum sizes (3 and 4) bring the auto-ready trigger, short packets and the byte writes ignored after a full packet within a few cycles.

// File: rtl/usb_txep_pkg.sv
package usb_txep_pkg;

  localparam int CTRL_W   = 5;
  localparam int CB_AUTO  = 0;
  localparam int CB_ISO   = 1;
  localparam int CB_DIR   = 2;
  localparam int CB_DMA   = 3;
  localparam int CB_FORCE = 4;

  typedef struct packed {
    logic dma_en;
    logic dir_tx;
    logic iso;
    logic auto_rdy;
  } txep_cfg_t;

  // Readback image of the control word; the force bit is a strobe and reads 0.
  function automatic logic [CTRL_W-1:0] cfg_to_bits(input txep_cfg_t c);
    logic [CTRL_W-1:0] r;
    r           = '0;
    r[CB_AUTO]  = c.auto_rdy;
    r[CB_ISO]   = c.iso;
    r[CB_DIR]   = c.dir_tx;
    r[CB_DMA]   = c.dma_en;
    r[CB_FORCE] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/usb_txep_cfg_regs.sv
module usb_txep_cfg_regs
  import usb_txep_pkg::*;
#(
  parameter int MAXP_W      = 11,
  parameter bit SHARED_FIFO = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [CTRL_W-1:0]    cfg_wr_data,
  input  logic                 maxp_wr_en,
  input  logic [MAXP_W-1:0]    maxp_wr_data,
  output txep_cfg_t            cfg,
  output logic                 force_pulse,
  output logic [MAXP_W-1:0]    maxp
);

  logic auto_q;
  logic iso_q;
  logic dma_q;
  logic dir_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0;
      iso_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else if (cfg_wr_en) begin
      auto_q <= cfg_wr_data[CB_AUTO];
      iso_q  <= cfg_wr_data[CB_ISO];
      dma_q  <= cfg_wr_data[CB_DMA];
    end
  end

  generate
    if (SHARED_FIFO) begin : g_shared_dir
      logic dir_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         dir_q <= 1'b0;
        else if (cfg_wr_en) dir_q <= cfg_wr_data[CB_DIR];
      end
      assign dir_tx = dir_q;
    end else begin : g_fixed_dir
      assign dir_tx = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          maxp <= '0;
    else if (maxp_wr_en) maxp <= maxp_wr_data;
  end

  // Force-toggle is never stored: it acts in the cycle of the write.
  assign force_pulse = cfg_wr_en && cfg_wr_data[CB_FORCE];

  always_comb begin
    cfg          = '0;
    cfg.auto_rdy = auto_q;
    cfg.iso      = iso_q;
    cfg.dir_tx   = dir_tx;
    cfg.dma_en   = dma_q;
  end

endmodule

// File: rtl/usb_txep_fill_cnt.sv
module usb_txep_fill_cnt #(
  parameter int MAXP_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_wr,
  input  logic              accept,
  input  logic              flush,
  input  logic              auto_en,
  input  logic [MAXP_W-1:0] maxp,
  output logic [MAXP_W-1:0] count,
  output logic              autoset_hit
);

  localparam logic [MAXP_W-1:0] CNT_MAX = {MAXP_W{1'b1}};

  // Saturating increment of the byte count.
  function automatic logic [MAXP_W-1:0] count_step(input logic [MAXP_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  // True when one more byte completes a packet of the programmed size.
  function automatic logic reaches_maxp(input logic [MAXP_W-1:0] c,
                                        input logic [MAXP_W-1:0] mp);
    logic [MAXP_W:0] nxt;
    nxt = {1'b0, c} + 1'b1;
    return (mp != '0) && (nxt == {1'b0, mp});
  endfunction

  logic take_byte;
  assign take_byte   = byte_wr && accept;
  assign autoset_hit = take_byte && auto_en && reaches_maxp(count, maxp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count <= '0;
    else if (flush)     count <= '0;
    else if (take_byte) count <= count_step(count);
  end

endmodule

// File: rtl/usb_txep_hs.sv
module usb_txep_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic autoset_hit,
  input  logic ack,
  input  logic sent,
  input  logic iso,
  input  logic dir_tx,
  input  logic force_tgl,
  output logic tx_ready,
  output logic toggle,
  output logic ack_done,
  output logic iso_done
);

  logic set_req;
  logic clr_req;
  logic flip_req;

  assign ack_done = tx_ready && !iso && ack;
  assign iso_done = tx_ready && iso && sent;
  assign set_req  = dir_tx && (sw_set || autoset_hit);
  assign clr_req  = force_tgl || ack_done || iso_done;
  assign flip_req = force_tgl || ack_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_ready <= 1'b0;
    else if (clr_req) tx_ready <= 1'b0;
    else if (set_req) tx_ready <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        toggle <= 1'b0;
    else if (flip_req) toggle <= ~toggle;
  end

endmodule

// File: rtl/usb_txep_ctrl.sv
module usb_txep_ctrl
  import usb_txep_pkg::*;
#(
  parameter int MAXP_W      = 11,
  parameter bit SHARED_FIFO = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CTRL_W-1:0] cfg_wr_data,
  input  logic              maxp_wr_en,
  input  logic [MAXP_W-1:0] maxp_wr_data,
  input  logic              fifo_wr,
  input  logic              sw_ready_set,
  input  logic              ack_rcvd,
  input  logic              pkt_sent,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [MAXP_W-1:0] maxp_rd,
  output logic [MAXP_W-1:0] byte_count,
  output logic              tx_ready,
  output logic              data_toggle,
  output logic              dma_req,
  output logic              fifo_flush
);

  txep_cfg_t         cfg;
  logic              ev_force;
  logic              ev_autoset;
  logic              ev_ack_done;
  logic              ev_iso_done;
  logic              ev_retire;
  logic [MAXP_W-1:0] maxp;

  usb_txep_cfg_regs #(
    .MAXP_W      (MAXP_W),
    .SHARED_FIFO (SHARED_FIFO)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_data  (cfg_wr_data),
    .maxp_wr_en   (maxp_wr_en),
    .maxp_wr_data (maxp_wr_data),
    .cfg          (cfg),
    .force_pulse  (ev_force),
    .maxp         (maxp)
  );

  assign ev_retire = ev_force || ev_ack_done || ev_iso_done;

  usb_txep_fill_cnt #(
    .MAXP_W (MAXP_W)
  ) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_wr     (fifo_wr),
    .accept      (cfg.dir_tx && !tx_ready),
    .flush       (ev_retire),
    .auto_en     (cfg.auto_rdy),
    .maxp        (maxp),
    .count       (byte_count),
    .autoset_hit (ev_autoset)
  );

  usb_txep_hs u_hs (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_set      (sw_ready_set),
    .autoset_hit (ev_autoset),
    .ack         (ack_rcvd),
    .sent        (pkt_sent),
    .iso         (cfg.iso),
    .dir_tx      (cfg.dir_tx),
    .force_tgl   (ev_force),
    .tx_ready    (tx_ready),
    .toggle      (data_toggle),
    .ack_done    (ev_ack_done),
    .iso_done    (ev_iso_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_flush <= 1'b0;
    else        fifo_flush <= ev_retire;
  end

  assign dma_req = cfg.dma_en && cfg.dir_tx && !tx_ready;
  assign ctrl_rd = cfg_to_bits(cfg);
  assign maxp_rd = maxp;

endmodule

// File: rtl/usb_txep_ctrl_chk.sv
module usb_txep_ctrl_chk
  import usb_txep_pkg::*;
#(
  parameter int MAXP_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [CTRL_W-1:0] cfg_wr_data,
  input logic              fifo_wr,
  input logic              sw_ready_set,
  input logic              ack_rcvd,
  input logic              pkt_sent,
  input logic [CTRL_W-1:0] ctrl_rd,
  input logic [MAXP_W-1:0] byte_count,
  input logic              tx_ready,
  input logic              data_toggle,
  input logic              dma_req,
  input logic              fifo_flush,
  input logic              ev_autoset
);

  logic force_wr;
  assign force_wr = cfg_wr_en && cfg_wr_data[CB_FORCE];

  a_r2_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[CB_FORCE] == 1'b0);

  a_r3_no_spontaneous_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !sw_ready_set && !ctrl_rd[CB_AUTO]) |=> !tx_ready);

  a_r4_autoset_raises_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_autoset && !force_wr) |=> tx_ready);

  a_r6_bulk_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !ctrl_rd[CB_ISO] && ack_rcvd && !force_wr)
      |=> (data_toggle != $past(data_toggle)) && !tx_ready && (byte_count == '0) && fifo_flush);

  a_r6_bulk_sent_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !ctrl_rd[CB_ISO] && !ack_rcvd && !force_wr) |=> tx_ready);

  a_r7_iso_keeps_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[CB_ISO] && !force_wr) |=> $stable(data_toggle));

  a_r7_iso_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && ctrl_rd[CB_ISO] && !pkt_sent && !force_wr) |=> tx_ready);

  a_r8_force_flush: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr |=> (data_toggle != $past(data_toggle)) && !tx_ready && (byte_count == '0) && fifo_flush);

  a_r9_dma_gating: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req == (ctrl_rd[CB_DMA] && ctrl_rd[CB_DIR] && !tx_ready));

  a_r10_rx_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd[CB_DIR] && !force_wr && !tx_ready) |=> (byte_count == $past(byte_count)) && !tx_ready);

  a_r11_count_frozen_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && fifo_wr && !ack_rcvd && !pkt_sent && !force_wr) |=> $stable(byte_count));

endmodule

bind usb_txep_ctrl usb_txep_ctrl_chk #(.MAXP_W(MAXP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_wr_data  (cfg_wr_data),
  .fifo_wr      (fifo_wr),
  .sw_ready_set (sw_ready_set),
  .ack_rcvd     (ack_rcvd),
  .pkt_sent     (pkt_sent),
  .ctrl_rd      (ctrl_rd),
  .byte_count   (byte_count),
  .tx_ready     (tx_ready),
  .data_toggle  (data_toggle),
  .dma_req      (dma_req),
  .fifo_flush   (fifo_flush),
  .ev_autoset   (ev_autoset)
);

// File: tb/tb_usb_txep_ctrl.sv
`timescale 1ns/1ps
module tb_usb_txep_ctrl;

  localparam int MAXP_W = 11;
  localparam int CNT_MAX = (1 << MAXP_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic [4:0]        cfg_wr_data = '0;
  logic              maxp_wr_en = 1'b0;
  logic [MAXP_W-1:0] maxp_wr_data = '0;
  logic              fifo_wr = 1'b0;
  logic              sw_ready_set = 1'b0;
  logic              ack_rcvd = 1'b0;
  logic              pkt_sent = 1'b0;
  logic [4:0]        ctrl_rd;
  logic [MAXP_W-1:0] maxp_rd;
  logic [MAXP_W-1:0] byte_count;
  logic              tx_ready;
  logic              data_toggle;
  logic              dma_req;
  logic              fifo_flush;

  int checks = 0;
  int errors = 0;
  logic exp_tog = 1'b0;

  always #5 clk = ~clk;

  usb_txep_ctrl #(.MAXP_W(MAXP_W), .SHARED_FIFO(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .maxp_wr_en(maxp_wr_en), .maxp_wr_data(maxp_wr_data), .fifo_wr(fifo_wr),
    .sw_ready_set(sw_ready_set), .ack_rcvd(ack_rcvd), .pkt_sent(pkt_sent),
    .ctrl_rd(ctrl_rd), .maxp_rd(maxp_rd), .byte_count(byte_count),
    .tx_ready(tx_ready), .data_toggle(data_toggle), .dma_req(dma_req),
    .fifo_flush(fifo_flush)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [4:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v; cyc(); cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  task automatic wr_maxp(input int v);
    maxp_wr_en = 1'b1; maxp_wr_data = MAXP_W'(v); cyc(); maxp_wr_en = 1'b0;
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      fifo_wr = 1'b1; cyc();
    end
    fifo_wr = 1'b0;
  endtask

  task automatic sw_set();
    sw_ready_set = 1'b1; cyc(); sw_ready_set = 1'b0;
  endtask

  task automatic ack();
    ack_rcvd = 1'b1; cyc(); ack_rcvd = 1'b0;
  endtask

  task automatic sent();
    pkt_sent = 1'b1; cyc(); pkt_sent = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl_rd", ctrl_rd, 0);
    chk("R1 maxp_rd", maxp_rd, 0);
    chk("R1 byte_count", byte_count, 0);
    chk("R1 tx_ready", tx_ready, 0);
    chk("R1 data_toggle", data_toggle, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 fifo_flush", fifo_flush, 0);
  endtask

  task automatic t_ctrl_rw();
    wr_ctrl(5'h1F); exp_tog = ~exp_tog;
    chk("R2 readback all set, force reads 0", ctrl_rd, 'h0F);
    chk("R8 toggle after force", data_toggle, exp_tog);
    wr_ctrl(5'h0A);
    chk("R2 readback iso+dma", ctrl_rd, 'h0A);
    wr_ctrl(5'h00);
    chk("R2 readback clear", ctrl_rd, 0);
    wr_maxp(4);
    chk("R2 maxp readback", maxp_rd, 4);
  endtask

  task automatic t_manual();
    wr_ctrl(5'h04);
    push(4);
    chk("R3 count after 4 bytes", byte_count, 4);
    chk("R3 no auto ready", tx_ready, 0);
    sw_set();
    chk("R3 sw ready", tx_ready, 1);
    sent();
    chk("R6 sent ignored in bulk", tx_ready, 1);
    ack(); exp_tog = ~exp_tog;
    chk("R6 ack clears ready", tx_ready, 0);
    chk("R6 ack clears count", byte_count, 0);
    chk("R6 ack flips toggle", data_toggle, exp_tog);
    chk("R6 flush pulse", fifo_flush, 1);
    cyc();
    chk("R6 flush one cycle", fifo_flush, 0);
  endtask

  task automatic t_auto();
    wr_ctrl(5'h05); wr_maxp(4);
    push(3);
    chk("R4 short packet not ready", tx_ready, 0);
    chk("R4 count 3", byte_count, 3);
    push(1);
    chk("R4 full packet ready", tx_ready, 1);
    chk("R4 count 4", byte_count, 4);
    push(2);
    chk("R11 count frozen while ready", byte_count, 4);
    ack(); exp_tog = ~exp_tog;
    chk("R6 toggle after auto packet", data_toggle, exp_tog);
    push(2);
    chk("R4 short packet still not ready", tx_ready, 0);
    sw_set();
    chk("R4 short packet sw ready", tx_ready, 1);
    ack(); exp_tog = ~exp_tog;
    chk("R6 short packet retired", tx_ready, 0);
  endtask

  task automatic t_maxp0();
    wr_ctrl(5'h05); wr_maxp(0);
    push(5);
    chk("R5 maxp 0 no auto ready", tx_ready, 0);
    chk("R5 count 5", byte_count, 5);
    sw_set(); ack(); exp_tog = ~exp_tog;
    chk("R5 retired", byte_count, 0);
  endtask

  task automatic t_iso();
    wr_ctrl(5'h07); wr_maxp(3);
    push(3);
    chk("R7 iso auto ready", tx_ready, 1);
    ack();
    chk("R7 ack ignored in iso", tx_ready, 1);
    chk("R7 toggle unchanged by ack", data_toggle, exp_tog);
    sent();
    chk("R7 sent clears ready", tx_ready, 0);
    chk("R7 sent clears count", byte_count, 0);
    chk("R7 flush pulse", fifo_flush, 1);
    chk("R7 toggle unchanged", data_toggle, exp_tog);
  endtask

  task automatic t_force();
    wr_ctrl(5'h05); wr_maxp(4);
    push(2);
    wr_ctrl(5'h15); exp_tog = ~exp_tog;
    chk("R8 force flips toggle", data_toggle, exp_tog);
    chk("R8 force clears count", byte_count, 0);
    chk("R8 force flush", fifo_flush, 1);
    chk("R8 force not stored", ctrl_rd, 'h05);
    push(4);
    chk("R8 refilled ready", tx_ready, 1);
    cfg_wr_en = 1'b1; cfg_wr_data = 5'h15; ack_rcvd = 1'b1;
    cyc();
    cfg_wr_en = 1'b0; cfg_wr_data = '0; ack_rcvd = 1'b0;
    exp_tog = ~exp_tog;
    chk("R8 force with ack flips once", data_toggle, exp_tog);
    chk("R8 force with ack clears ready", tx_ready, 0);
  endtask

  task automatic t_dma();
    wr_ctrl(5'h0C);
    chk("R9 dma when empty", dma_req, 1);
    sw_set();
    chk("R9 no dma when ready", dma_req, 0);
    ack(); exp_tog = ~exp_tog;
    chk("R9 dma after retire", dma_req, 1);
    wr_ctrl(5'h08);
    chk("R9 no dma in rx", dma_req, 0);
    wr_ctrl(5'h04);
    chk("R9 no dma when disabled", dma_req, 0);
  endtask

  task automatic t_rx();
    wr_ctrl(5'h01); wr_maxp(2);
    push(3);
    chk("R10 rx ignores bytes", byte_count, 0);
    chk("R10 rx no auto ready", tx_ready, 0);
    sw_set();
    chk("R10 rx ignores sw set", tx_ready, 0);
  endtask

  task automatic t_sat();
    wr_ctrl(5'h04); wr_maxp(0);
    push(CNT_MAX + 3);
    chk("R12 count saturates", byte_count, CNT_MAX);
    wr_ctrl(5'h14); exp_tog = ~exp_tog;
    chk("R12 flushed after saturation", byte_count, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_ctrl_rw();
    t_manual();
    t_auto();
    t_maxp0();
    t_iso();
    t_force();
    t_dma();
    t_rx();
    t_sat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule